// File: doc/BRIEF.md
# Interrupt Pending and Delivery Unit

This unit holds one pending flag for each of eight interrupt levels and decides, every cycle, whether the processor core should take an interrupt exception. Other logic posts or retires single levels by index. A single strobe wipes the whole vector. An on-core timer compares a free-running count against a compare value, and on a match it raises the pending level chosen by a 3-bit selector.

Delivery is gated by three status flags: a global enable, an error-level flag and an exception-level flag. It is also gated by an 8-bit mask. The core sees the pending vector, a flag that is high when anything is pending, and the take-interrupt request. A post or clear with an index outside the implemented levels changes nothing and produces a one-cycle error pulse.

All outputs are registered. A request presented in the cycle before a rising clock edge is visible on the outputs right after that edge. The take-interrupt request combines the status inputs of that same cycle with the pending vector as it stands after the edge.

Top module: `irq_pend_unit`

## Requirements
- R1: After synchronous reset, `pend`, `any_pend`, `take_irq`, `idx_err` and `cnt_val` are all zero, and the compare register is zero.
- R2: A post (`post_vld`=1) with `post_idx`=n, where n is 0 to 7, sets `pend[n]` at the next edge and leaves every other pending bit unchanged.
- R3: A clear (`clr_vld`=1) with `clr_idx`=n, where n is 0 to 7, resets `pend[n]` at the next edge and leaves every other pending bit unchanged.
- R4: `clr_all`=1 makes `pend` zero at the next edge. It overrides any post, clear or timer set in the same cycle.
- R5: When a post and a clear name the same level in the same cycle, the bit ends up set.
- R6: A post or clear whose 4-bit index is 8 to 15 leaves `pend` unchanged. `idx_err` is 1 for exactly the one cycle after that request.
- R7: `cnt_val` increments by one at each edge. When `cnt_wr`=1 it instead loads `cnt_wdata`. When `cmp_wr`=1 the compare register loads `cmp_wdata`.
- R8: While `cnt_val` equals the compare register and `cnt_val` is nonzero, the next edge sets `pend[tmr_sel]`. While `cnt_val` is zero, no timer set happens.
- R9: `any_pend` is 1 exactly when `pend` is nonzero.
- R10: After an edge, `take_irq` is 1 exactly when three things held: in the preceding cycle `irq_en`=1, `err_lvl`=0 and `exc_lvl`=0, and `irq_mask & pend` (using `pend` after the edge) is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_vld | input | 1 | Post request strobe |
| post_idx | input | 4 | Level index to post |
| clr_vld | input | 1 | Clear request strobe |
| clr_idx | input | 4 | Level index to clear |
| clr_all | input | 1 | Clear every pending level |
| irq_en | input | 1 | Global interrupt enable |
| err_lvl | input | 1 | Error-level flag, blocks delivery when 1 |
| exc_lvl | input | 1 | Exception-level flag, blocks delivery when 1 |
| irq_mask | input | 8 | Per-level delivery mask |
| cnt_wr | input | 1 | Load strobe for the count register |
| cnt_wdata | input | 32 | Count load value |
| cmp_wr | input | 1 | Load strobe for the compare register |
| cmp_wdata | input | 32 | Compare load value |
| tmr_sel | input | 3 | Pending level driven by a timer match |
| pend | output | 8 | Pending vector |
| any_pend | output | 1 | Any level pending |
| take_irq | output | 1 | Request to take an interrupt exception |
| idx_err | output | 1 | One-cycle pulse for an out-of-range index |
| cnt_val | output | 32 | Current count value |

## Verification
Posts and clears are applied to single levels, to several levels in turn, and to the same level together. This separates a correct per-bit update from one that disturbs neighbouring bits or gives clear the wrong priority. The delivery gate is tried with each blocking flag raised alone and with a mask that misses the pending level, so that each gating term is shown to act on its own. The timer is tried with a nonzero match, with a zero count equal to a zero compare, and with a match that coincides with clear-all. These cases tell apart the nonzero rule, the selector routing and the clear-all priority.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DEF_LVLS  = 8;
  localparam int DEF_IDX_W = 4;
  localparam int DEF_CNT_W = 32;
  localparam int DEF_SEL_W = $clog2(DEF_LVLS);
endpackage

// File: rtl/lvl_decode.sv
module lvl_decode #(
  parameter int NUM_LVL = irq_pkg::DEF_LVLS,
  parameter int IDX_W   = irq_pkg::DEF_IDX_W
) (
  input  logic               vld,
  input  logic [IDX_W-1:0]   idx,
  output logic [NUM_LVL-1:0] oh,
  output logic               bad
);
  localparam logic [IDX_W:0] LIM = (IDX_W+1)'(NUM_LVL);

  for (genvar i = 0; i < NUM_LVL; i++) begin : g_dec
    assign oh[i] = vld && (idx == IDX_W'(i));
  end

  assign bad = vld && ({1'b0, idx} >= LIM);
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit #(
  parameter int NUM_LVL = irq_pkg::DEF_LVLS,
  parameter int CNT_W   = irq_pkg::DEF_CNT_W,
  parameter int SEL_W   = irq_pkg::DEF_SEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cnt_wr,
  input  logic [CNT_W-1:0]   cnt_wdata,
  input  logic               cmp_wr,
  input  logic [CNT_W-1:0]   cmp_wdata,
  input  logic [SEL_W-1:0]   sel,
  output logic [CNT_W-1:0]   cnt_q,
  output logic [NUM_LVL-1:0] tmr_oh
);
  logic [CNT_W-1:0] cmp_q;
  logic             match;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      cmp_q <= '0;
    end else begin
      cnt_q <= cnt_wr ? cnt_wdata : cnt_q + CNT_W'(1);
      if (cmp_wr) cmp_q <= cmp_wdata;
    end
  end

  assign match = (cnt_q == cmp_q) && (cnt_q != '0);

  for (genvar i = 0; i < NUM_LVL; i++) begin : g_sel
    assign tmr_oh[i] = match && (sel == SEL_W'(i));
  end

  // R7
  cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> cnt_q == $past(cnt_wdata));
  // R7
  cnt_incr_chk: assert property (@(posedge clk) disable iff (rst)
    !cnt_wr |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  // R8
  tmr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tmr_oh));
endmodule

// File: rtl/pend_reg.sv
module pend_reg #(
  parameter int NUM_LVL = irq_pkg::DEF_LVLS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_all,
  input  logic [NUM_LVL-1:0] set_vec,
  input  logic [NUM_LVL-1:0] clr_vec,
  output logic [NUM_LVL-1:0] pend_nxt,
  output logic [NUM_LVL-1:0] pend_q
);
  always_comb begin
    if (clr_all) pend_nxt = '0;
    else         pend_nxt = (pend_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_nxt;
  end

  // R4
  clr_all_chk: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> pend_q == '0);
  // R2
  set_hits_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_all && set_vec != '0) |=> (pend_q & $past(set_vec)) == $past(set_vec));
  // R3
  clr_hits_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_vec & ~set_vec) != '0 |=> (pend_q & $past(clr_vec & ~set_vec)) == '0);
  // R2
  others_kept_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_all |=> ((pend_q ^ $past(pend_q)) & ~$past(set_vec | clr_vec)) == '0);
endmodule

// File: rtl/irq_pend_unit.sv
module irq_pend_unit #(
  parameter int NUM_LVL = irq_pkg::DEF_LVLS,
  parameter int IDX_W   = irq_pkg::DEF_IDX_W,
  parameter int CNT_W   = irq_pkg::DEF_CNT_W,
  parameter int SEL_W   = irq_pkg::DEF_SEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               post_vld,
  input  logic [IDX_W-1:0]   post_idx,
  input  logic               clr_vld,
  input  logic [IDX_W-1:0]   clr_idx,
  input  logic               clr_all,
  input  logic               irq_en,
  input  logic               err_lvl,
  input  logic               exc_lvl,
  input  logic [NUM_LVL-1:0] irq_mask,
  input  logic               cnt_wr,
  input  logic [CNT_W-1:0]   cnt_wdata,
  input  logic               cmp_wr,
  input  logic [CNT_W-1:0]   cmp_wdata,
  input  logic [SEL_W-1:0]   tmr_sel,
  output logic [NUM_LVL-1:0] pend,
  output logic               any_pend,
  output logic               take_irq,
  output logic               idx_err,
  output logic [CNT_W-1:0]   cnt_val
);
  logic [NUM_LVL-1:0] post_oh, clr_oh, tmr_oh, pend_nxt;
  logic               post_bad, clr_bad, gate_ok;

  lvl_decode #(.NUM_LVL(NUM_LVL), .IDX_W(IDX_W)) i_post_dec (
    .vld(post_vld), .idx(post_idx), .oh(post_oh), .bad(post_bad));

  lvl_decode #(.NUM_LVL(NUM_LVL), .IDX_W(IDX_W)) i_clr_dec (
    .vld(clr_vld), .idx(clr_idx), .oh(clr_oh), .bad(clr_bad));

  tmr_unit #(.NUM_LVL(NUM_LVL), .CNT_W(CNT_W), .SEL_W(SEL_W)) i_tmr (
    .clk(clk), .rst(rst), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .sel(tmr_sel),
    .cnt_q(cnt_val), .tmr_oh(tmr_oh));

  pend_reg #(.NUM_LVL(NUM_LVL)) i_pend (
    .clk(clk), .rst(rst), .clr_all(clr_all),
    .set_vec(post_oh | tmr_oh), .clr_vec(clr_oh),
    .pend_nxt(pend_nxt), .pend_q(pend));

  assign gate_ok = irq_en && !err_lvl && !exc_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      any_pend <= 1'b0;
      take_irq <= 1'b0;
      idx_err  <= 1'b0;
    end else begin
      any_pend <= |pend_nxt;
      take_irq <= gate_ok && |(irq_mask & pend_nxt);
      idx_err  <= post_bad || clr_bad;
    end
  end

  // R9
  any_match_chk: assert property (@(posedge clk) disable iff (rst)
    any_pend == (pend != '0));
  // R10
  take_gate_chk: assert property (@(posedge clk) disable iff (rst)
    take_irq |-> $past(irq_en && !err_lvl && !exc_lvl));
  // R10
  take_mask_chk: assert property (@(posedge clk) disable iff (rst)
    take_irq |-> (pend & $past(irq_mask)) != '0);
  // R6
  bad_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (post_bad || clr_bad) |=> idx_err);
  // R6
  bad_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (post_bad && !clr_vld && !clr_all && tmr_oh == '0) |=> pend == $past(pend));
endmodule

// File: tb/test_irq_pend_unit.sv
`timescale 1ns/1ps
module test_irq_pend_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        post_vld = 0, clr_vld = 0, clr_all = 0;
  logic [3:0]  post_idx = 0, clr_idx = 0;
  logic        irq_en = 0, err_lvl = 0, exc_lvl = 0;
  logic [7:0]  irq_mask = 0;
  logic        cnt_wr = 0, cmp_wr = 0;
  logic [31:0] cnt_wdata = 0, cmp_wdata = 0;
  logic [2:0]  tmr_sel = 0;
  logic [7:0]  pend;
  logic        any_pend, take_irq, idx_err;
  logic [31:0] cnt_val;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_pend_unit i_irq_pend_unit (
    .clk(clk), .rst(rst), .post_vld(post_vld), .post_idx(post_idx),
    .clr_vld(clr_vld), .clr_idx(clr_idx), .clr_all(clr_all),
    .irq_en(irq_en), .err_lvl(err_lvl), .exc_lvl(exc_lvl), .irq_mask(irq_mask),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .tmr_sel(tmr_sel), .pend(pend), .any_pend(any_pend), .take_irq(take_irq),
    .idx_err(idx_err), .cnt_val(cnt_val));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    post_vld = 0; clr_vld = 0; clr_all = 0; cnt_wr = 0; cmp_wr = 0;
  endtask

  task automatic wipe();
    idle(); clr_all = 1; tick(); idle();
  endtask

  task automatic t_reset();
    rst = 1; tick(); tick(); rst = 0;
    chk("R1 pend", {24'd0, pend}, 0);
    chk("R1 any", {31'd0, any_pend}, 0);
    chk("R1 take", {31'd0, take_irq}, 0);
    chk("R1 err", {31'd0, idx_err}, 0);
    chk("R1 cnt", cnt_val, 0);
  endtask

  task automatic t_post_clear();
    post_vld = 1; post_idx = 2; tick(); idle();
    chk("R2 post 2", {24'd0, pend}, 32'h04);
    chk("R9 any set", {31'd0, any_pend}, 1);
    post_vld = 1; post_idx = 7; tick(); idle();
    chk("R2 post 7", {24'd0, pend}, 32'h84);
    post_vld = 1; post_idx = 0; tick(); idle();
    chk("R2 post 0", {24'd0, pend}, 32'h85);
    clr_vld = 1; clr_idx = 7; tick(); idle();
    chk("R3 clr 7", {24'd0, pend}, 32'h05);
    clr_vld = 1; clr_idx = 3; tick(); idle();
    chk("R3 clr idle bit", {24'd0, pend}, 32'h05);
    clr_vld = 1; clr_idx = 0; tick(); clr_idx = 2; tick(); idle();
    chk("R3 clr all bits", {24'd0, pend}, 0);
    chk("R9 any clear", {31'd0, any_pend}, 0);
  endtask

  task automatic t_collide();
    post_vld = 1; post_idx = 4; clr_vld = 1; clr_idx = 4; tick(); idle();
    chk("R5 post beats clear", {24'd0, pend}, 32'h10);
    post_vld = 1; post_idx = 1; clr_vld = 1; clr_idx = 4; tick(); idle();
    chk("R5 distinct levels", {24'd0, pend}, 32'h02);
    post_vld = 1; post_idx = 6; clr_all = 1; tick(); idle();
    chk("R4 clear-all beats post", {24'd0, pend}, 0);
    chk("R9 any after wipe", {31'd0, any_pend}, 0);
  endtask

  task automatic t_bad_idx();
    post_vld = 1; post_idx = 3; tick(); idle();
    post_vld = 1; post_idx = 9; tick(); idle();
    chk("R6 post 9 ignored", {24'd0, pend}, 32'h08);
    chk("R6 err pulse", {31'd0, idx_err}, 1);
    tick();
    chk("R6 err one cycle", {31'd0, idx_err}, 0);
    clr_vld = 1; clr_idx = 11; tick(); idle();
    chk("R6 clr 11 ignored", {24'd0, pend}, 32'h08);
    chk("R6 err pulse clr", {31'd0, idx_err}, 1);
    post_vld = 1; post_idx = 8; tick(); idle();
    chk("R6 post 8 ignored", {24'd0, pend}, 32'h08);
    wipe();
  endtask

  task automatic t_gate();
    irq_en = 1; irq_mask = 8'h08; post_vld = 1; post_idx = 3; tick(); idle();
    chk("R10 take on", {31'd0, take_irq}, 1);
    err_lvl = 1; tick();
    chk("R10 error level blocks", {31'd0, take_irq}, 0);
    err_lvl = 0; exc_lvl = 1; tick();
    chk("R10 exception level blocks", {31'd0, take_irq}, 0);
    exc_lvl = 0; irq_en = 0; tick();
    chk("R10 enable off blocks", {31'd0, take_irq}, 0);
    irq_en = 1; irq_mask = 8'hF7; tick();
    chk("R10 mask misses", {31'd0, take_irq}, 0);
    chk("R9 any with mask miss", {31'd0, any_pend}, 1);
    irq_mask = 8'h08; tick();
    chk("R10 take again", {31'd0, take_irq}, 1);
    clr_vld = 1; clr_idx = 3; tick(); idle();
    chk("R10 take after clear", {31'd0, take_irq}, 0);
    irq_en = 0; irq_mask = 0;
  endtask

  task automatic t_counter();
    cnt_wr = 1; cnt_wdata = 32'd1000; tick(); idle();
    chk("R7 load", cnt_val, 1000);
    for (int k = 0; k < 5; k++) tick();
    chk("R7 increment", cnt_val, 1005);
    cnt_wr = 1; cnt_wdata = 32'hFFFF_FFFF; tick(); idle(); tick();
    chk("R7 wrap", cnt_val, 0);
  endtask

  task automatic t_timer();
    cmp_wr = 1; cmp_wdata = 32'd100; tick(); idle();
    tmr_sel = 3'd5; cnt_wr = 1; cnt_wdata = 32'd100; tick(); idle();
    chk("R8 no set before edge", {24'd0, pend}, 0);
    tick();
    chk("R8 match sets sel 5", {24'd0, pend}, 32'h20);
    chk("R9 any timer", {31'd0, any_pend}, 1);
    clr_vld = 1; clr_idx = 5; tick(); idle();
    chk("R8 no repeat once past", {24'd0, pend}, 0);
    cnt_wr = 1; cnt_wdata = 32'd98; tmr_sel = 3'd1; tick(); idle();
    tick(); tick();
    chk("R8 counted match pending", {24'd0, pend}, 0);
    tick();
    chk("R8 counted match sets sel 1", {24'd0, pend}, 32'h02);
    wipe();
    cmp_wr = 1; cmp_wdata = 32'd200; tick(); idle();
    cnt_wr = 1; cnt_wdata = 32'd200; tick(); idle();
    clr_all = 1; tick(); idle();
    chk("R4 clear-all beats timer", {24'd0, pend}, 0);
    cmp_wr = 1; cmp_wdata = 32'd0; cnt_wr = 1; cnt_wdata = 32'd0; tick();
    tick(); tick(); idle(); tick();
    chk("R8 zero count no set", {24'd0, pend}, 0);
  endtask

  initial begin
    t_reset();
    t_post_clear();
    t_collide();
    t_bad_idx();
    t_gate();
    t_counter();
    t_timer();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule